// File: doc/BRIEF.md
# Debounced Pin Event Detector

This block conditions a single general-purpose input and turns it into interrupt and wake events. The raw pin is first brought into the system clock domain by a two-flop synchronizer. It then passes through a glitch filter whose timeout is a 4-bit count multiplied by one of four time bases. The time bases are measured in ticks of a slow real-time-clock-rate strobe. The filter can let through, in the immediate direction, low-going or high-going glitches, remove glitches in both directions, or be bypassed entirely.

The filtered level drives the trigger logic. In edge mode it detects a rising edge, a falling edge or both. In level mode it reports while the pin sits at the active level. Each event sets a sticky wake status, and also a sticky interrupt status when interrupts are enabled. Both status bits are cleared by a write-1 pulse. The interrupt request output is the interrupt status gated by the enable bit and the unmask bit. Software programs the configuration inputs and services the status bits.

Top module: `pin_event_detector`

## Requirements
- R1: After reset, `pin_level`, `int_sts`, `wake_sts` and `irq` are all 0.
- R2: The debounce unit is selected by `{db_large_sel, db_unit_sel}`: 00 gives UNIT_A (2), 01 gives UNIT_B (8), 10 gives UNIT_C (512) and 11 gives UNIT_D (2048) ticks. The timeout is the count times the unit. With `rtc_tick` held high, a debounced change reaches `pin_level` on the (2 + timeout)-th rising clock edge after the pin changes.
- R3: A `db_count` of 0 with debouncing active behaves as a count of 1.
- R4: With `db_type` = 3 (remove both), a change in either direction must persist for the full timeout. A pulse shorter than the timeout never reaches `pin_level`, and the timeout counter restarts whenever the synchronized input returns to the filtered value. No progress is made on cycles without `rtc_tick`.
- R5: With `db_type` = 1 (keep low glitches), a falling change passes with no debounce and a rising change is debounced. With `db_type` = 2 (keep high glitches), the opposite holds.
- R6: With `db_type` = 0 (filter off), `pin_level` follows the pin with a latency of 3 rising edges, in both directions and at any count.
- R7: With `trig_level` = 0 (edge mode), `trig_pol` selects the event: 0 rising, 1 falling, 2 both edges, 3 none.
- R8: With `trig_level` = 1 (level mode), `trig_pol` 0 gives an event on every cycle the filtered level is 1, and `trig_pol` 1 on every cycle it is 0. Codes 2 and 3 give no event.
- R9: Status bits are sticky. A 1 on `int_sts_clr` or `wake_sts_clr` clears its bit on the next edge, unless an event happens in the same cycle. An active level therefore keeps re-setting the status through a clear.
- R10: `wake_sts` is set by every event. `int_sts` is set only when `int_enable` is 1.
- R11: `irq` is 1 only when the interrupt status is set and both `int_enable` and `int_unmask` are 1; a `int_unmask` of 1 means unmasked. It is updated on the same edge as `int_sts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous pin input |
| rtc_tick | input | 1 | One-cycle strobe at the slow time-base rate |
| db_count | input | CNT_W | Debounce count |
| db_unit_sel | input | 1 | Time-base select, low bit |
| db_large_sel | input | 1 | Time-base select, high bit |
| db_type | input | 2 | 0 off, 1 keep low glitches, 2 keep high glitches, 3 remove both |
| trig_level | input | 1 | 0 edge mode, 1 level mode |
| trig_pol | input | 2 | 0 high/rising, 1 low/falling, 2 both edges |
| int_enable | input | 1 | Interrupt enable |
| int_unmask | input | 1 | 1 lets the interrupt reach `irq` |
| int_sts_clr | input | 1 | Write-1 clear of the interrupt status |
| wake_sts_clr | input | 1 | Write-1 clear of the wake status |
| pin_level | output | 1 | Filtered pin level |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check on every cycle that the timeout counter stays below its limit and advances only while the synchronized and filtered levels differ. They also check that the filtered level only ever moves to the synchronized value, that status bits hold until a clear, and that `irq` never appears without the status and both gate bits. The exact timeout lengths for every count and time base, the suppression of short glitches, and the direction-dependent behaviour of the glitch styles can only be shown by the bench. The same holds for the mapping of each trigger mode and polarity to events and for the clear-versus-active-level race; the bench measures latencies and sweeps these settings.

// File: rtl/pev_pkg.sv
package pev_pkg;
  typedef enum logic [1:0] {
    DB_OFF       = 2'd0,
    DB_KEEP_LOW  = 2'd1,
    DB_KEEP_HIGH = 2'd2,
    DB_REMOVE    = 2'd3
  } db_type_e;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_BOTH = 2'd2,
    POL_NONE = 2'd3
  } trig_pol_e;
endpackage

// File: rtl/pev_sync.sv
module pev_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pev_debounce.sv
module pev_debounce
  import pev_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int UNIT_A = 2,
  parameter int UNIT_B = 8,
  parameter int UNIT_C = 512,
  parameter int UNIT_D = 2048,
  localparam int TW    = $clog2(UNIT_D * ((1 << CNT_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             unit_sel,
  input  logic             large_sel,
  input  db_type_e         style,
  output logic             filt
);
  logic [TW-1:0]    unit_t;
  logic [CNT_W-1:0] eff_cnt;
  logic [TW-1:0]    limit;
  logic [TW-1:0]    tcnt;
  logic             slow_dir;

  always_comb begin
    case ({large_sel, unit_sel})
      2'b00:   unit_t = TW'(UNIT_A);
      2'b01:   unit_t = TW'(UNIT_B);
      2'b10:   unit_t = TW'(UNIT_C);
      default: unit_t = TW'(UNIT_D);
    endcase
    eff_cnt = (count == '0) ? CNT_W'(1) : count;
    limit   = TW'(eff_cnt) * unit_t;
    // is the move toward sync_in subject to the timeout?
    case (style)
      DB_REMOVE:    slow_dir = 1'b1;
      DB_KEEP_LOW:  slow_dir = sync_in;
      DB_KEEP_HIGH: slow_dir = !sync_in;
      default:      slow_dir = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b0;
      tcnt <= '0;
    end else if (!slow_dir) begin
      filt <= sync_in;
      tcnt <= '0;
    end else if (sync_in == filt) begin
      tcnt <= '0;
    end else if (tick) begin
      if (tcnt >= limit - TW'(1)) begin
        filt <= sync_in;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(limit) == limit && $past(tcnt) < $past(limit)) |-> tcnt < limit);
  // R4
  count_only_on_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    (tcnt != '0) |-> $past(sync_in != filt));
  // R4
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> filt == $past(sync_in));
endmodule

// File: rtl/pev_trigger.sv
module pev_trigger
  import pev_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level_in,
  input  logic      level_mode,
  input  trig_pol_e pol,
  input  logic      int_en,
  input  logic      unmask,
  input  logic      int_clr,
  input  logic      wake_clr,
  output logic      int_sts,
  output logic      wake_sts,
  output logic      irq
);
  logic prev_lvl;
  logic rise, fall, evt;
  logic int_n, wake_n;

  always_comb begin
    rise = level_in && !prev_lvl;
    fall = !level_in && prev_lvl;
    evt  = 1'b0;
    if (level_mode) begin
      case (pol)
        POL_HIGH: evt = level_in;
        POL_LOW:  evt = !level_in;
        default:  evt = 1'b0;
      endcase
    end else begin
      case (pol)
        POL_HIGH: evt = rise;
        POL_LOW:  evt = fall;
        POL_BOTH: evt = rise || fall;
        default:  evt = 1'b0;
      endcase
    end
    int_n  = (int_sts && !int_clr) || (evt && int_en);
    wake_n = (wake_sts && !wake_clr) || evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      int_sts  <= 1'b0;
      wake_sts <= 1'b0;
      irq      <= 1'b0;
    end else begin
      prev_lvl <= level_in;
      int_sts  <= int_n;
      wake_sts <= wake_n;
      irq      <= int_n && int_en && unmask;
    end
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(int_sts) && !$past(int_clr)) |-> int_sts);
  // R10
  int_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_sts) |-> $past(int_en));
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (int_sts && $past(int_en) && $past(unmask)));
  // R8
  no_event_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_sts) |-> !$past(pol == POL_NONE || (level_mode && pol == POL_BOTH)));
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pev_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int UNIT_A      = 2,
  parameter int UNIT_B      = 8,
  parameter int UNIT_C      = 512,
  parameter int UNIT_D      = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_raw,
  input  logic             rtc_tick,
  input  logic [CNT_W-1:0] db_count,
  input  logic             db_unit_sel,
  input  logic             db_large_sel,
  input  logic [1:0]       db_type,
  input  logic             trig_level,
  input  logic [1:0]       trig_pol,
  input  logic             int_enable,
  input  logic             int_unmask,
  input  logic             int_sts_clr,
  input  logic             wake_sts_clr,
  output logic             pin_level,
  output logic             int_sts,
  output logic             wake_sts,
  output logic             irq
);
  logic pin_s;

  pev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_raw),
    .d_out (pin_s)
  );

  pev_debounce #(
    .CNT_W (CNT_W),
    .UNIT_A(UNIT_A),
    .UNIT_B(UNIT_B),
    .UNIT_C(UNIT_C),
    .UNIT_D(UNIT_D)
  ) u_db (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (pin_s),
    .tick     (rtc_tick),
    .count    (db_count),
    .unit_sel (db_unit_sel),
    .large_sel(db_large_sel),
    .style    (db_type_e'(db_type)),
    .filt     (pin_level)
  );

  pev_trigger u_trig (
    .clk       (clk),
    .rst       (rst),
    .level_in  (pin_level),
    .level_mode(trig_level),
    .pol       (trig_pol_e'(trig_pol)),
    .int_en    (int_enable),
    .unmask    (int_unmask),
    .int_clr   (int_sts_clr),
    .wake_clr  (wake_sts_clr),
    .int_sts   (int_sts),
    .wake_sts  (wake_sts),
    .irq       (irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(pin_level || int_sts || wake_sts || irq));
endmodule

// File: tb/tb_pin_event_detector.sv
`timescale 1ns/1ps
module tb_pin_event_detector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0, rtc_tick = 1'b1;
  logic [3:0] db_count = '0;
  logic       db_unit_sel = 1'b0, db_large_sel = 1'b0;
  logic [1:0] db_type = 2'd0;
  logic       trig_level = 1'b0;
  logic [1:0] trig_pol = 2'd0;
  logic       int_enable = 1'b1, int_unmask = 1'b1;
  logic       int_sts_clr = 1'b0, wake_sts_clr = 1'b0;
  logic       pin_level, int_sts, wake_sts, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pin_event_detector dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .rtc_tick(rtc_tick),
    .db_count(db_count), .db_unit_sel(db_unit_sel), .db_large_sel(db_large_sel),
    .db_type(db_type), .trig_level(trig_level), .trig_pol(trig_pol),
    .int_enable(int_enable), .int_unmask(int_unmask),
    .int_sts_clr(int_sts_clr), .wake_sts_clr(wake_sts_clr),
    .pin_level(pin_level), .int_sts(int_sts), .wake_sts(wake_sts), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive the pin and count rising edges until pin_level follows
  task automatic meas(input logic v, output int n);
    @(negedge clk);
    pin_raw = v;
    n = 0;
    while (n < 40000) begin
      @(posedge clk);
      n++;
      #1;
      if (pin_level == v) break;
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    int_sts_clr = 1'b1; wake_sts_clr = 1'b1;
    @(negedge clk);
    int_sts_clr = 1'b0; wake_sts_clr = 1'b0;
    cyc(1);
  endtask

  function automatic int unit_of(input logic lg, input logic un);
    case ({lg, un})
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 512;
      default: return 2048;
    endcase
  endfunction

  function automatic bit lvl_active(input logic [1:0] pol, input logic v);
    return (pol == 2'd0 && v) || (pol == 2'd1 && !v);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n, lim, exp_b, exp_a;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(!pin_level && !int_sts && !wake_sts && !irq, "R1 reset outputs", int'({pin_level, int_sts, wake_sts, irq}), 0);

    // R6 filter off: latency 3 regardless of count
    db_type = 2'd0; db_count = 4'd9;
    meas(1'b1, n); chk(n == 3, "R6 off rise latency", n, 3);
    meas(1'b0, n); chk(n == 3, "R6 off fall latency", n, 3);

    // R2/R3 sweep: remove-both, small time bases, all counts
    db_type = 2'd3;
    for (int lu = 0; lu < 2; lu++) begin
      for (int c = 0; c < 16; c++) begin
        db_large_sel = 1'b0; db_unit_sel = lu[0]; db_count = c[3:0];
        lim = ((c == 0) ? 1 : c) * unit_of(1'b0, lu[0]);
        meas(1'b1, n); chk(n == 2 + lim, (c == 0) ? "R3 count0 rise" : "R2 rise timeout", n, 2 + lim);
        meas(1'b0, n); chk(n == 2 + lim, (c == 0) ? "R3 count0 fall" : "R2 fall timeout", n, 2 + lim);
      end
    end
    // R2 large time bases
    for (int u = 0; u < 2; u++) begin
      db_large_sel = 1'b1; db_unit_sel = u[0]; db_count = 4'd1;
      lim = unit_of(1'b1, u[0]);
      meas(1'b1, n); chk(n == 2 + lim, "R2 large rise", n, 2 + lim);
      db_count = 4'd0;
      meas(1'b0, n); chk(n == 2 + lim, "R3 large count0 fall", n, 2 + lim);
    end

    // R4 glitch shorter than timeout (limit 4) is removed
    db_large_sel = 1'b0; db_unit_sel = 1'b0; db_count = 4'd2;
    @(negedge clk); pin_raw = 1'b1;
    cyc(3); pin_raw = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pin_level) seen = 1; end
      chk(!seen, "R4 short glitch removed", seen, 0);
    end
    // R4 counter restart: two 3-cycle pulses separated by a low still give no change
    @(negedge clk); pin_raw = 1'b1; cyc(3); pin_raw = 1'b0; cyc(1); pin_raw = 1'b1; cyc(3); pin_raw = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pin_level) seen = 1; end
      chk(!seen, "R4 restart after return", seen, 0);
    end
    // R4 no progress without ticks
    rtc_tick = 1'b0;
    @(negedge clk); pin_raw = 1'b1;
    cyc(50);
    chk(!pin_level, "R4 no tick holds level", pin_level, 0);
    rtc_tick = 1'b1;
    cyc(8);
    chk(pin_level, "R4 tick resumes", pin_level, 1);
    meas(1'b0, n);

    // R5 keep-low: fall immediate, rise debounced (limit 4)
    db_type = 2'd1;
    meas(1'b1, n); chk(n == 6, "R5 keep-low rise debounced", n, 6);
    meas(1'b0, n); chk(n == 3, "R5 keep-low fall immediate", n, 3);
    // R5 keep-high: rise immediate, fall debounced
    db_type = 2'd2;
    meas(1'b1, n); chk(n == 3, "R5 keep-high rise immediate", n, 3);
    meas(1'b0, n); chk(n == 6, "R5 keep-high fall debounced", n, 6);

    // R7/R8/R9/R10/R11 trigger sweep with filter off
    db_type = 2'd0;
    for (int lv = 0; lv < 2; lv++) begin
      for (int p = 0; p < 4; p++) begin
        for (int p0 = 0; p0 < 2; p0++) begin
          trig_level = lv[0]; trig_pol = p[1:0];
          @(negedge clk); pin_raw = p0[0];
          cyc(10);
          clear_all();
          exp_b = (lv == 1) ? int'(lvl_active(p[1:0], p0[0])) : 0;
          chk(int_sts == exp_b[0], lv ? "R8 level status after clear (R9)" : "R7 edge status after clear (R9)", int_sts, exp_b);
          chk(wake_sts == exp_b[0], "R10 wake after clear", wake_sts, exp_b);
          @(negedge clk); pin_raw = !p0[0];
          cyc(6);
          if (lv == 1) exp_a = exp_b | int'(lvl_active(p[1:0], !p0[0]));
          else exp_a = int'((p0 == 0 && (p == 0 || p == 2)) || (p0 == 1 && (p == 1 || p == 2)));
          chk(int_sts == exp_a[0], lv ? "R8 level event" : "R7 edge event", int_sts, exp_a);
          chk(irq == exp_a[0], "R11 irq follows status", irq, exp_a);
        end
      end
    end

    // R10 interrupt disabled: wake only
    trig_level = 1'b0; trig_pol = 2'd2; int_enable = 1'b0;
    clear_all();
    @(negedge clk); pin_raw = !pin_raw;
    cyc(6);
    chk(!int_sts, "R10 int disabled no status", int_sts, 0);
    chk(wake_sts, "R10 wake set when int disabled", wake_sts, 1);
    chk(!irq, "R11 irq off when disabled", irq, 0);

    // R11 masked then unmasked
    int_enable = 1'b1; int_unmask = 1'b0;
    clear_all();
    @(negedge clk); pin_raw = !pin_raw;
    cyc(6);
    chk(int_sts, "R11 status set while masked", int_sts, 1);
    chk(!irq, "R11 masked irq low", irq, 0);
    int_unmask = 1'b1;
    cyc(1);
    chk(irq, "R11 unmask raises irq", irq, 1);
    // R9 clear wins when no event
    clear_all();
    chk(!int_sts && !irq, "R9 write-1 clear", int'({int_sts, irq}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule